// File: doc/BRIEF.md
# Processor Memory Register Interface with Two-Cycle Read

This block holds the registers that sit between a microprogrammed processor datapath and a synchronous memory. On the data side there is a word address register and a word data register. On the instruction side there is a program counter and an 8-bit instruction byte buffer. The controller raises read, write and fetch strobes. The block turns them into memory port signals. It loads the returned data into the proper register at a fixed point in time.

The word address register counts in 32-bit words, so the block multiplies it by four to form the byte address it sends to memory. The program counter already holds a byte address and goes out unchanged. Data comes back with an exact latency. A strobe raised in cycle k gives a value the datapath can use in cycle k+2. In cycle k+1 the register still shows what it held before. The controller can also load the address register, the data register and the program counter from a shared 32-bit write bus. The byte buffer is offered to the datapath in two 32-bit forms: sign-extended and zero-extended.

Top module: `memreg_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four registers clear to zero. The four registers are the word address register, the word data register, the program counter and the byte buffer.
- R2: Each of `ld_mar`, `ld_mdr` and `ld_pc` loads `wbus` into its own register at the rising edge that closes the cycle. The register's output shows the new value from the next cycle on.
- R3: `mem_addr` equals the word address register shifted left by two bit positions, with bits 1:0 at zero. `mem_rd` and `mem_wr` follow `rd_req` and `wr_req` in the same cycle.
- R4: After a read strobe in cycle k, the data register takes the `mem_rdata` value that memory presents in cycle k+1. `mdr_q` shows that value from cycle k+2 on. In cycle k+1, `mdr_q` still holds its earlier contents.
- R5: Read strobes in consecutive cycles each complete two cycles after they were issued, in issue order. Each one returns the word for the address it was issued with.
- R6: If a read completes in the same cycle that `ld_mdr` is high, the memory data is stored and the bus value is dropped.
- R7: During a write strobe, `mem_wdata` carries the current data register and `mem_addr` carries the scaled address, both in that same cycle. A write changes no register.
- R8: `fetch_addr` equals the program counter with no scaling, and `fetch_rd` follows `fetch_req`. A fetch in cycle k loads `fetch_rdata` (as presented in cycle k+1) into the byte buffer, which shows it from cycle k+2.
- R9: `mbr_sext` is the byte buffer with bit 7 copied into bits 31:8. `mbr_zext` is the byte buffer with bits 31:8 at zero.
- R10: A read and a fetch may be issued in the same cycle or overlap. Each completes on its own schedule without disturbing the other.
- R11: A strobe uses the register values of the cycle in which it is raised. Loading the address register or the program counter in that same cycle does not redirect the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wbus | input | 32 | Write bus from the datapath |
| ld_mar | input | 1 | Load word address register from wbus |
| ld_mdr | input | 1 | Load data register from wbus |
| ld_pc | input | 1 | Load program counter from wbus |
| rd_req | input | 1 | Word read strobe |
| wr_req | input | 1 | Word write strobe |
| fetch_req | input | 1 | Instruction byte fetch strobe |
| mar_q | output | 32 | Word address register |
| mdr_q | output | 32 | Data register |
| pc_q | output | 32 | Program counter |
| mbr_sext | output | 32 | Byte buffer, sign-extended |
| mbr_zext | output | 32 | Byte buffer, zero-extended |
| mem_addr | output | 32 | Byte address for word access |
| mem_rd | output | 1 | Word read to memory |
| mem_wr | output | 1 | Word write to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Word read data, valid the cycle after the read |
| fetch_addr | output | 32 | Byte address for instruction fetch |
| fetch_rd | output | 1 | Byte fetch to memory |
| fetch_rdata | input | 8 | Fetched byte, valid the cycle after the fetch |

## Verification
The bench's memory model puts random data on the read buses in every cycle that is not a read result. A design that captures one cycle early or one cycle late therefore stores a wrong value. A design that shows the new data already in cycle k+1 fails the check that the old value is still held. The bench issues reads in consecutive cycles while the address register changes every cycle. A design with a single pending slot, or one that samples the address late, returns the wrong word for one of the reads. The bench also loads the data register in the exact cycle a read completes, and fetches bytes with bit 7 both set and clear. These cases catch an inverted priority and a sign-extension error.

// File: rtl/memreg_pkg.sv
// Package memreg_pkg
// Purpose : shared widths and the per-cycle completion record used by the
//           memory register interface.
// Assumes : the memory returns data one cycle after it samples a strobe, so
//           the block needs one stage of pending-access tracking.
package memreg_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int RD_STAGES = 1;

    // One flag per access kind that may be in flight
    typedef struct packed {
        logic word;
        logic fetch;
    } rd_slot_t;
endpackage

// File: rtl/memreg_rd_tracker.sv
// Module  : memreg_rd_tracker
// Purpose : delays the read and fetch strobes by STAGES cycles, so that the
//           owning registers capture returned data in exactly the right cycle.
// Assumes : one strobe of each kind per cycle at most; the stages are
//           independent, so reads and fetches may overlap freely.
module memreg_rd_tracker
    import memreg_pkg::*;
#(
    parameter int STAGES = RD_STAGES
) (
    input  logic     clk,
    input  logic     rst_n,
    input  rd_slot_t req,
    output rd_slot_t done
);
    rd_slot_t stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage: capture the strobes raised this cycle
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= req;
            end
        end else begin : g_tail
            // Later stages: shift the pending flags along
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign done = stage_q[STAGES-1];
endmodule

// File: rtl/memreg_word_side.sv
// Module  : memreg_word_side
// Purpose : word address and data registers, plus forming the byte address.
// Assumes : rd_done marks the cycle in which rdata holds a read result; that
//           result takes priority over a load from the write bus.
module memreg_word_side #(
    parameter int W     = 32,
    parameter int SHIFT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wbus,
    input  logic         ld_mar,
    input  logic         ld_mdr,
    input  logic         rd_done,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] mar_q,
    output logic [W-1:0] mdr_q,
    output logic [W-1:0] byte_addr
);
    // Address register: loads from the write bus only
    always_ff @(posedge clk) begin
        if (!rst_n)      mar_q <= '0;
        else if (ld_mar) mar_q <= wbus;
    end

    // Data register: read result first, bus load second, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)       mdr_q <= '0;
        else if (rd_done) mdr_q <= rdata;
        else if (ld_mdr)  mdr_q <= wbus;
    end

    // Word to byte address scaling
    assign byte_addr = mar_q << SHIFT;

    assert_mar_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mar |=> (mar_q == $past(wbus)));

    assert_mdr_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (mdr_q == $past(rdata)));
endmodule

// File: rtl/memreg_fetch_side.sv
// Module  : memreg_fetch_side
// Purpose : program counter and instruction byte buffer, with the buffer
//           offered as sign- and zero-extended words.
// Assumes : f_done marks the cycle in which fbyte holds a fetched byte.
module memreg_fetch_side #(
    parameter int W  = 32,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  wbus,
    input  logic          ld_pc,
    input  logic          f_done,
    input  logic [BW-1:0] fbyte,
    output logic [W-1:0]  pc_q,
    output logic [W-1:0]  mbr_sext,
    output logic [W-1:0]  mbr_zext
);
    localparam int PAD = W - BW;

    logic [BW-1:0] mbr_q;

    // Program counter: loads from the write bus only
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (ld_pc) pc_q <= wbus;
    end

    // Byte buffer: loads only when a fetch completes
    always_ff @(posedge clk) begin
        if (!rst_n)      mbr_q <= '0;
        else if (f_done) mbr_q <= fbyte;
    end

    // Two widened views of the byte buffer
    assign mbr_sext = {{PAD{mbr_q[BW-1]}}, mbr_q};
    assign mbr_zext = {{PAD{1'b0}}, mbr_q};

    assert_pc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pc |=> (pc_q == $past(wbus)));
endmodule

// File: rtl/memreg_unit.sv
// Module  : memreg_unit
// Purpose : top of the memory register interface. It routes the controller
//           strobes to the memory ports and returns read data into the data
//           register and the byte buffer. A result is visible two cycles after
//           its strobe.
// Assumes : a synchronous memory that samples address and strobe at a rising
//           edge and drives read data through the following cycle.
module memreg_unit
    import memreg_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  wbus,
    input  logic          ld_mar,
    input  logic          ld_mdr,
    input  logic          ld_pc,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          fetch_req,
    output logic [W-1:0]  mar_q,
    output logic [W-1:0]  mdr_q,
    output logic [W-1:0]  pc_q,
    output logic [W-1:0]  mbr_sext,
    output logic [W-1:0]  mbr_zext,
    output logic [W-1:0]  mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic [W-1:0]  fetch_addr,
    output logic          fetch_rd,
    input  logic [BW-1:0] fetch_rdata
);
    localparam int SHIFT = $clog2(W / BW);

    rd_slot_t strobes, done;

    assign strobes.word  = rd_req;
    assign strobes.fetch = fetch_req;

    memreg_rd_tracker #(.STAGES(RD_STAGES)) u_track (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (strobes),
        .done (done)
    );

    memreg_word_side #(.W(W), .SHIFT(SHIFT)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .wbus     (wbus),
        .ld_mar   (ld_mar),
        .ld_mdr   (ld_mdr),
        .rd_done  (done.word),
        .rdata    (mem_rdata),
        .mar_q    (mar_q),
        .mdr_q    (mdr_q),
        .byte_addr(mem_addr)
    );

    memreg_fetch_side #(.W(W), .BW(BW)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wbus    (wbus),
        .ld_pc   (ld_pc),
        .f_done  (done.fetch),
        .fbyte   (fetch_rdata),
        .pc_q    (pc_q),
        .mbr_sext(mbr_sext),
        .mbr_zext(mbr_zext)
    );

    // Memory port: strobes pass straight through, using this cycle's registers
    assign mem_rd     = rd_req;
    assign mem_wr     = wr_req;
    assign mem_wdata  = mdr_q;
    assign fetch_addr = pc_q;
    assign fetch_rd   = fetch_req;

    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ##1 (mdr_q == $past(mem_rdata)));

    assert_mdr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mem_rd) && !ld_mdr) |=> $stable(mdr_q));

    assert_fetch_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rd |=> ##1 (mbr_zext[BW-1:0] == $past(fetch_rdata)));
endmodule

// File: tb/memreg_unit_test.sv
module memreg_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] wbus;
    logic        ld_mar, ld_mdr, ld_pc, rd_req, wr_req, fetch_req;
    logic [31:0] mar_q, mdr_q, pc_q, mbr_sext, mbr_zext;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, fetch_addr;
    logic        mem_rd, mem_wr, fetch_rd;
    logic [7:0]  fetch_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] e_mar, e_mdr, e_pc, p_ra, p_fa;
    logic [7:0]  e_mbr;
    logic        p_rd, p_f;

    always #4 clk = ~clk;

    memreg_unit uut (
        .clk(clk), .rst_n(rst_n), .wbus(wbus),
        .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_pc(ld_pc),
        .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
        .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q),
        .mbr_sext(mbr_sext), .mbr_zext(mbr_zext),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fetch_addr(fetch_addr), .fetch_rd(fetch_rd), .fetch_rdata(fetch_rdata)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [7:0] byte_of(input logic [31:0] a);
        return a[7:0] ^ 8'h5C;
    endfunction

    function automatic logic [31:0] sx(input logic [7:0] b);
        return {{24{b[7]}}, b};
    endfunction

    // Memory model: answers a strobe in the next cycle, garbage otherwise
    always @(posedge clk) begin
        mem_rdata   <= mem_rd   ? word_of(mem_addr)   : $urandom;
        fetch_rdata <= fetch_rd ? byte_of(fetch_addr) : 8'($urandom);
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check ports, clock, update model, check regs
    task automatic step(input string tag, input logic [31:0] bus,
                        input logic lmar, input logic lmdr, input logic lpc,
                        input logic rd, input logic wr, input logic fe);
        logic [31:0] n_mdr;
        wbus = bus; ld_mar = lmar; ld_mdr = lmdr; ld_pc = lpc;
        rd_req = rd; wr_req = wr; fetch_req = fe;
        #1;
        chk(tag, "mem_addr", mem_addr, e_mar << 2);
        chk(tag, "mem_rd", 32'(mem_rd), 32'(rd));
        chk(tag, "mem_wr", 32'(mem_wr), 32'(wr));
        if (wr) chk(tag, "mem_wdata", mem_wdata, e_mdr);
        chk(tag, "fetch_addr", fetch_addr, e_pc);
        chk(tag, "fetch_rd", 32'(fetch_rd), 32'(fe));
        @(posedge clk);
        n_mdr = p_rd ? word_of(p_ra) : (lmdr ? bus : e_mdr);
        if (p_f) e_mbr = byte_of(p_fa);
        p_rd = rd; p_ra = e_mar << 2;
        p_f  = fe; p_fa = e_pc;
        if (lmar) e_mar = bus;
        if (lpc)  e_pc  = bus;
        e_mdr = n_mdr;
        @(negedge clk);
        chk(tag, "mar_q", mar_q, e_mar);
        chk(tag, "mdr_q", mdr_q, e_mdr);
        chk(tag, "pc_q", pc_q, e_pc);
        chk(tag, "mbr_sext", mbr_sext, sx(e_mbr));
        chk(tag, "mbr_zext", mbr_zext, {24'h0, e_mbr});
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20511);
        rst_n = 1'b0; wbus = 32'hFFFF_FFFF;
        ld_mar = 1; ld_mdr = 1; ld_pc = 1; rd_req = 1; wr_req = 0; fetch_req = 1;
        e_mar = 0; e_mdr = 0; e_pc = 0; e_mbr = 0; p_rd = 0; p_f = 0; p_ra = 0; p_fa = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: everything clear under reset
        chk("R1", "mar_q", mar_q, 0);
        chk("R1", "mdr_q", mdr_q, 0);
        chk("R1", "pc_q", pc_q, 0);
        chk("R1", "mbr_zext", mbr_zext, 0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0, 0, 0);
        // R2: bus loads
        step("R2", 32'h0000_0010, 1, 0, 0, 0, 0, 0);
        step("R2", 32'h0000_1234, 0, 1, 0, 0, 0, 0);
        step("R2", 32'h0000_0080, 0, 0, 1, 0, 0, 0);
        // R3 / R4: single read, old value held one cycle
        step("R3", 0, 0, 0, 0, 1, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 0, 0);
        // R11: load MAR in the read cycle, read must use old address
        step("R11", 32'h0000_0033, 1, 0, 0, 1, 0, 0);
        step("R11", 0, 0, 0, 0, 0, 0, 0);
        step("R11", 0, 0, 0, 0, 0, 0, 0);
        // R5: back-to-back reads with address changing every cycle
        step("R5", 32'h0000_0101, 1, 0, 0, 1, 0, 0);
        step("R5", 32'h0000_0202, 1, 0, 0, 1, 0, 0);
        step("R5", 32'h0000_0303, 1, 0, 0, 1, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 0, 0);
        // R6: bus load in the completion cycle loses, next one wins
        step("R6", 0, 0, 0, 0, 1, 0, 0);
        step("R6", 32'hCAFE_0001, 0, 1, 0, 0, 0, 0);
        step("R6", 32'hCAFE_0002, 0, 1, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 0, 0);
        // R7: write carries current MDR, registers unchanged
        step("R7", 32'hAAAA_5555, 0, 0, 0, 0, 1, 0);
        step("R7", 0, 0, 0, 0, 0, 0, 0);
        // R8 / R9: fetch a negative byte (PC=0x80) then a positive one (PC=0x01)
        step("R8", 0, 0, 0, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0);
        step("R9", 32'h0000_0001, 0, 0, 1, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 1);
        step("R9", 0, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0);
        // R10: read and fetch together, overlapping with PC and MAR changes
        step("R10", 32'h0000_0044, 1, 0, 1, 1, 0, 1);
        step("R10", 32'h0000_0081, 0, 0, 1, 1, 0, 1);
        step("R10", 0, 0, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 0);
        // R5 / R10 mixed: random traffic
        for (int i = 0; i < 400; i++) begin
            logic [5:0] r;
            r = 6'($urandom);
            step("R5", $urandom, r[0], r[1], r[2], r[3], r[4], r[5]);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule